// File: doc/BRIEF.md
# Multichannel Pulse-Width Event Recorder

This block watches a set of one-bit input channels at the same time for one recording window. The window is measured in ticks of an external 1 µs strobe. For every pulse on a channel it takes the tick count at the rising edge and at the falling edge. It keeps only the pulses whose width reaches a minimum. For each kept pulse it stores the two timestamps as a pair in that channel's own table.

A record command clears the timestamp counter and opens the window. The window closes after a fixed number of ticks, or earlier on a stop command. The block then presents every table entry to a serial transmitter, one value at a time. Each value is offered with a start level and is advanced only when the transmitter reports that the packet is finished. A flag marks the end of the unload.

Top module: `pulse_event_recorder`

## Requirements
- R1: After reset the block is idle: `tx_start` and `unload_done` are low.
- R2: Ticks that arrive before a record command do not advance the timestamp counter. A record command accepted while idle or finished clears the counter to 0 and starts recording. Each tick then adds 1, so a timestamp equals the number of ticks since the command.
- R3: Every channel passes through a two-flop synchronizer. A rising edge takes the current count as the start time, and the following falling edge takes the current count as the end time.
- R4: A pulse is kept only if end minus start is at least `MIN_W` ticks. A shorter pulse writes nothing and does not use up a slot.
- R5: The k-th kept pulse of a channel (k from 0) stores its start in slot 2k and its end in slot 2k+1. Once `SLOTS/2` pulses are kept on a channel, further pulses on that channel are dropped.
- R6: The window closes when the counter reaches `WINDOW`. A pulse still high at that moment gets the end time `WINDOW` and is qualified by R4.
- R7: A stop command during recording closes the window at the current count. Open pulses are closed at that count and qualified by R4.
- R8: The unload sends slots 0 to `SLOTS-1` of channel 0, then the same slots of channel 1, and so on. A slot that was never written is sent as 0.
- R9: `tx_data` holds its value while `tx_start` is high and `tx_done` is low. In the cycle after `tx_done` is seen with `tx_start` high, `tx_start` is low for one cycle, and then the next value is presented.
- R10: `unload_done` rises only after the last entry of the last channel is acknowledged. It stays high until the next record command, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| rec_cmd | input | 1 | Record command pulse |
| stop_cmd | input | 1 | Stop command pulse |
| ch_in | input | NCH | Asynchronous channel levels |
| tx_done | input | 1 | Transmitter end-of-packet |
| tx_start | output | 1 | Transmit request for the value on tx_data |
| tx_data | output | TS_W | Table value being offered |
| unload_done | output | 1 | Whole table has been sent |

## Verification
The case that is hardest to reach from the ports is a pulse that is still open when the window ends, either by expiry or by a stop command. In that case the end time comes from the close event and not from an edge. The bench sets channel levels tick by tick from per-channel level maps, so a channel can be held high across the final tick or across a stop issued at a chosen tick. It also runs directed maps: pulses one tick below and exactly at the width limit, and a dense pulse train that fills a channel's table past its capacity. Random maps with widths clustered around the limit cover the remaining cases.

// File: rtl/pulse_event_recorder.sv
module pulse_event_recorder #(
  parameter int NCH    = 4,
  parameter int TS_W   = 12,
  parameter int WINDOW = 3200,
  parameter int MIN_W  = 100,
  parameter int SLOTS  = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_us,
  input  logic            rec_cmd,
  input  logic            stop_cmd,
  input  logic [NCH-1:0]  ch_in,
  input  logic            tx_done,
  output logic            tx_start,
  output logic [TS_W-1:0] tx_data,
  output logic            unload_done
);
  localparam int SW   = $clog2(SLOTS);
  localparam int PW   = $clog2(SLOTS / 2 + 1);
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PAIRS = SLOTS / 2;

  typedef enum logic [1:0] {IDLE, REC, UNLD, FIN} st_t;

  st_t              st;
  logic [TS_W-1:0]  tcnt;
  logic [NCH-1:0]   s1, s2, prev, open;
  logic [TS_W-1:0]  start_ts [NCH];
  logic [PW-1:0]    pcnt [NCH];
  logic [TS_W-1:0]  mem [NCH][SLOTS];
  logic [CW-1:0]    uch;
  logic [SW-1:0]    uslot;
  logic             gap;
  logic [NCH-1:0]   wr;

  wire [NCH-1:0] rise    = s2 & ~prev;
  wire [NCH-1:0] fall    = ~s2 & prev;
  wire           win_end = (st == REC) && (stop_cmd || tcnt == TS_W'(WINDOW));
  wire           last    = (uch == CW'(NCH - 1)) && (uslot == SW'(SLOTS - 1));

  function automatic logic [SW-1:0] slot_of(input logic [PW-1:0] p, input logic odd);
    return SW'({p, odd});
  endfunction

  always_comb begin
    for (int c = 0; c < NCH; c++)
      wr[c] = (st == REC) && open[c] && (win_end || fall[c]) &&
              ((tcnt - start_ts[c]) >= TS_W'(MIN_W)) && (pcnt[c] < PW'(PAIRS));
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++)
      if (wr[c]) begin
        mem[c][slot_of(pcnt[c], 1'b0)] <= start_ts[c];
        mem[c][slot_of(pcnt[c], 1'b1)] <= tcnt;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      tcnt  <= '0;
      s1    <= '0;
      s2    <= '0;
      prev  <= '0;
      open  <= '0;
      uch   <= '0;
      uslot <= '0;
      gap   <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        start_ts[c] <= '0;
        pcnt[c]     <= '0;
      end
    end else begin
      s1   <= ch_in;
      s2   <= s1;
      prev <= s2;
      case (st)
        IDLE, FIN: if (rec_cmd) begin
          st   <= REC;
          tcnt <= '0;
          open <= '0;
          for (int c = 0; c < NCH; c++) pcnt[c] <= '0;
        end
        REC: begin
          for (int c = 0; c < NCH; c++) begin
            if (wr[c]) pcnt[c] <= pcnt[c] + 1'b1;
            if (win_end) open[c] <= 1'b0;
            else if (rise[c]) begin
              open[c]     <= 1'b1;
              start_ts[c] <= tcnt;
            end else if (fall[c]) open[c] <= 1'b0;
          end
          if (win_end) begin
            st    <= UNLD;
            uch   <= '0;
            uslot <= '0;
            gap   <= 1'b0;
          end else if (tick_us) tcnt <= tcnt + 1'b1;
        end
        UNLD: begin
          if (gap) gap <= 1'b0;
          else if (tx_done) begin
            gap <= 1'b1;
            if (last) st <= FIN;
            else if (uslot == SW'(SLOTS - 1)) begin
              uslot <= '0;
              uch   <= uch + 1'b1;
            end else uslot <= uslot + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  wire [PW:0] filled = {pcnt[uch], 1'b0};
  assign tx_start    = (st == UNLD) && !gap;
  assign tx_data     = ((PW + 1)'(uslot) < filled) ? mem[uch][uslot] : '0;
  assign unload_done = (st == FIN);
endmodule

// File: rtl/pulse_event_recorder_chk.sv
module pulse_event_recorder_chk #(
  parameter int TS_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rec_cmd,
  input logic            tx_start,
  input logic            tx_done,
  input logic [TS_W-1:0] tx_data,
  input logic            unload_done
);
  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start && !tx_done |=> tx_start && $stable(tx_data));
  // R9
  gap_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start && tx_done |=> !tx_start);
  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(unload_done && tx_start));
  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unload_done) |-> $past(tx_start && tx_done));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unload_done && !rec_cmd |=> unload_done);
endmodule

bind pulse_event_recorder pulse_event_recorder_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_cmd(rec_cmd), .tx_start(tx_start),
  .tx_done(tx_done), .tx_data(tx_data), .unload_done(unload_done)
);

// File: tb/tb_pulse_event_recorder.sv
module tb_pulse_event_recorder;
  localparam int NCH = 3, TS_W = 12, WINDOW = 300, MIN_W = 20, SLOTS = 8;
  localparam int NW = NCH * SLOTS;

  logic clk = 0, rst_n = 0, tick_us = 0, rec_cmd = 0, stop_cmd = 0, tx_done = 0;
  logic [NCH-1:0] ch_in = '0;
  wire tx_start, unload_done;
  wire [TS_W-1:0] tx_data;

  pulse_event_recorder #(.NCH(NCH), .TS_W(TS_W), .WINDOW(WINDOW), .MIN_W(MIN_W), .SLOTS(SLOTS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .rec_cmd(rec_cmd), .stop_cmd(stop_cmd),
    .ch_in(ch_in), .tx_done(tx_done), .tx_start(tx_start), .tx_data(tx_data),
    .unload_done(unload_done));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit lvl [NCH][WINDOW];
  int expv [NW];

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    repeat (3) @(negedge clk);
    tick_us = 1;
    @(negedge clk);
    tick_us = 0;
  endtask

  task automatic apply(int t);
    for (int c = 0; c < NCH; c++) ch_in[c] = lvl[c][t];
  endtask

  function automatic void clear_lvl();
    for (int c = 0; c < NCH; c++)
      for (int t = 0; t < WINDOW; t++) lvl[c][t] = 0;
  endfunction

  function automatic void set_run(int c, int a, int b);
    for (int t = a; t <= b && t < WINDOW; t++) lvl[c][t] = 1;
  endfunction

  function automatic void gen_random(int c);
    int t = 0;
    bit v = 0;
    while (t < WINDOW) begin
      int len;
      if (!v) len = 1 + int'($urandom % 25);
      else case ($urandom % 4)
        0: len = MIN_W - 1;
        1: len = MIN_W;
        2: len = MIN_W + 1;
        default: len = 1 + int'($urandom % 40);
      endcase
      for (int k = 0; k < len && t < WINDOW; k++) begin
        lvl[c][t] = v;
        t++;
      end
      v = !v;
    end
  endfunction

  function automatic void build_exp(int end_t);
    for (int i = 0; i < NW; i++) expv[i] = 0;
    for (int c = 0; c < NCH; c++) begin
      int cnt = 0, s = 0;
      bit op = 0, pv = 0;
      for (int t = 0; t < end_t; t++) begin
        bit v = lvl[c][t];
        if (v && !pv) begin op = 1; s = t; end
        else if (!v && pv && op) begin
          if (t - s >= MIN_W && cnt < SLOTS / 2) begin
            expv[c*SLOTS + 2*cnt] = s; expv[c*SLOTS + 2*cnt + 1] = t; cnt++;
          end
          op = 0;
        end
        pv = v;
      end
      if (op && end_t - s >= MIN_W && cnt < SLOTS / 2) begin
        expv[c*SLOTS + 2*cnt] = s; expv[c*SLOTS + 2*cnt + 1] = end_t;
      end
    end
  endfunction

  // R2: ticks before the command must not move the counter
  task automatic record(int stop_t);
    repeat (3) do_tick();
    @(negedge clk); rec_cmd = 1;
    @(negedge clk); rec_cmd = 0;
    check("R10 flag cleared by record", int'(unload_done), 0);
    apply(0);
    for (int t = 1; t <= WINDOW; t++) begin
      do_tick();
      if (t == stop_t) begin
        stop_cmd = 1;
        @(negedge clk); stop_cmd = 0;
        break;
      end
      if (t == WINDOW) break;
      apply(t);
    end
    ch_in = '0;
  endtask

  task automatic unload(string req);
    for (int i = 0; i < NW; i++) begin
      while (!tx_start) @(negedge clk);
      check(req, int'(tx_data), expv[i]);
      repeat ($urandom % 3) @(negedge clk);
      check("R9 data held until done", int'(tx_data), expv[i]);
      tx_done = 1;
      @(negedge clk); tx_done = 0;
      check("R9 start drops after done", int'(tx_start), 0);
    end
    check("R10 done after last entry", int'(unload_done), 1);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 tx_start after reset", int'(tx_start), 0);
    check("R1 unload_done after reset", int'(unload_done), 0);

    // R4 width limit, R6 pulse open at window end, R8 empty channel sends zeros
    clear_lvl();
    set_run(0, 10, 28);
    set_run(0, 50, 69);
    set_run(1, 280, WINDOW - 1);
    build_exp(WINDOW);
    record(WINDOW + 1);
    unload("R4/R6 directed");

    // R5 table saturation
    clear_lvl();
    for (int k = 0; k < 10; k++) set_run(0, k*30, k*30 + 24);
    gen_random(1);
    set_run(2, 100, 100 + MIN_W - 2);
    build_exp(WINDOW);
    record(WINDOW + 1);
    unload("R5 saturation");

    // R7 early stop with open pulse
    clear_lvl();
    for (int c = 0; c < NCH; c++) gen_random(c);
    set_run(2, 120, 160);
    build_exp(150);
    record(150);
    unload("R7 stop");

    // R3/R8 random maps over the full window
    for (int r = 0; r < 3; r++) begin
      clear_lvl();
      for (int c = 0; c < NCH; c++) gen_random(c);
      build_exp(WINDOW);
      record(WINDOW + 1);
      unload("R3/R8 random");
    end

    summary();
    $finish;
  end
endmodule